// File: doc/BRIEF.md
# Receive Framing Status and Interrupt Controller

This block follows the framing condition of a receive frame processor through three states: locked (in-frame), searching after a loss (out-of-frame), and declared lost after the search timed out (un-framed). A framing detector upstream feeds it three qualified single-cycle pulses: framing lost, persistence timeout and framing acquired. The block moves its state one step around a fixed cycle, drives an out-of-frame pin and a loss-of-frame pin, and latches two change events for software.

Each event records a change of one of the two pins. Software can mask it, and it raises a level interrupt. The loss-of-frame change event covers both edges of the loss-of-frame pin, and the out-of-frame change event covers both edges of the out-of-frame pin. The step from un-framed back to in-frame moves both pins at once, so it sets both events. A handler tells which edge caused an event by reading the two-bit state field in the status readback byte.

Software reaches the block through a small byte-wide register port. Offset 0 is the status readback. Offset 1 holds the interrupt events and clears when read. Offset 2 is the read/write interrupt mask. Offset 3 is unmapped.

Top module: `plcp_frm_irq`

## Requirements
- R1: After reset the state is un-framed. rxOof and rxLof are both 1, the event byte and the mask byte read 0, and irq is 0.
- R2: The state changes only one step at a time, in the order in-frame → out-of-frame (on evLost) → un-framed (on evTimeout) → in-frame (on evAcquired). The change is visible one clock after the pulse. rxOof is 1 in out-of-frame and in un-framed. rxLof is 1 only in un-framed.
- R3: An event pulse that does not match the current state leaves the state, the pins and the event byte unchanged. evLost is accepted only in in-frame, evTimeout only in out-of-frame, and evAcquired only in un-framed.
- R4: Reading offset 0 returns bit 2 = out-of-frame and bit 1 = loss-of-frame. This gives 0x00 in in-frame, 0x04 in out-of-frame and 0x06 in un-framed. All other bits read 0, and the read has no side effect.
- R5: Event bit 0 (loss-of-frame change) is set by the out-of-frame → un-framed step and by the un-framed → in-frame step.
- R6: Event bit 1 (out-of-frame change) is set by the in-frame → out-of-frame step and by the un-framed → in-frame step.
- R7: Event bits stay set until offset 1 is read. That read returns the bits as they stood, and the bits are clear on the next read.
- R8: An event that arrives in the same cycle as a read of offset 1 is not lost. The bit is set after that clock.
- R9: At offset 2, mask bit 0 enables event bit 0 and mask bit 1 enables event bit 1. Writing 1 enables and writing 0 disables. Bits 7:2 read 0 and ignore writes. Writes to offsets 0, 1 and 3 have no effect, and offset 3 reads 0.
- R10: irq is 1 exactly when some event bit is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evLost | input | 1 | Framing-lost pulse from the detector |
| evTimeout | input | 1 | Persistence-timeout pulse |
| evAcquired | input | 1 | Framing-acquired pulse |
| regAddr | input | 2 | Register offset |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; a read of offset 1 clears the event byte at the clock edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the current offset (combinational) |
| rxOof | output | 1 | Out-of-frame indication |
| rxLof | output | 1 | Loss-of-frame indication |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default 2-bit offset and 8-bit data widths. The state space is small, so the sweep can be exhaustive. It covers all three states crossed with all eight combinations of the three event pulses, and checks the next state, both pins and the latched event byte each time. It also covers every mask value crossed with each of the three event-producing steps, together with a read of offset 1 that coincides with an event and writes that carry ones in every unused bit.

// File: rtl/plcp_frm_irq_pkg.sv
package plcp_frm_irq_pkg;

  // State encoding doubles as readback field {oof, lof}
  typedef enum logic [1:0] {
    ST_INFRAME  = 2'b00,
    ST_OOF      = 2'b10,
    ST_UNFRAMED = 2'b11
  } frmState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic oofChg;
    logic lofChg;
  } frmStrobe_t;

  localparam int unsigned EVT_BITS = 2;

endpackage

// File: rtl/frm_state_ctrl.sv
module frm_state_ctrl
  import plcp_frm_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evLost,
  input  logic       evTimeout,
  input  logic       evAcquired,
  output frmState_t  state,
  output frmStrobe_t strobes
);

  frmState_t stateNxt;
  logic takeLost, takeTimeout, takeAcq;

  always_comb begin
    takeLost    = (state == ST_INFRAME)  && evLost;
    takeTimeout = (state == ST_OOF)      && evTimeout;
    takeAcq     = (state == ST_UNFRAMED) && evAcquired;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_INFRAME:  if (evLost)     stateNxt = ST_OOF;
      ST_OOF:      if (evTimeout)  stateNxt = ST_UNFRAMED;
      ST_UNFRAMED: if (evAcquired) stateNxt = ST_INFRAME;
      default:                     stateNxt = ST_UNFRAMED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_UNFRAMED;
    else       state <= stateNxt;
  end

  // Pin-change strobes, registered by the datapath together with the state
  always_comb begin
    strobes.lofChg = takeTimeout || takeAcq;
    strobes.oofChg = takeLost    || takeAcq;
  end

  // R2
  acq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UNFRAMED && evAcquired) |=> (state == ST_INFRAME));

  // R2
  lost_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INFRAME && evLost) |=> (state == ST_OOF));

  // R3
  inframe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INFRAME && !evLost) |=> (state == ST_INFRAME));

  // R3
  oof_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OOF && !evTimeout) |=> $stable(state));

  // R2
  legal_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'b01);

endmodule

// File: rtl/frm_irq_datapath.sv
module frm_irq_datapath
  import plcp_frm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CFG_ADDR = 0,
  parameter int unsigned ISR_ADDR = 1,
  parameter int unsigned IER_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  frmState_t         state,
  input  frmStrobe_t        strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);

  localparam logic [DATA_W-1:0] EN_MASK = DATA_W'((1 << EVT_BITS) - 1);

  logic [EVT_BITS-1:0] setVec;
  logic [EVT_BITS-1:0] intStat;
  logic [DATA_W-1:0]   intEn;
  logic                rdIsr, wrIer;

  assign setVec = {strobes.oofChg, strobes.lofChg};
  assign rdIsr  = regRd && (regAddr == ADDR_W'(ISR_ADDR));
  assign wrIer  = regWr && (regAddr == ADDR_W'(IER_ADDR));

  // One sticky cell per event bit; a new event wins over the clearing read
  for (genvar i = 0; i < EVT_BITS; i++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) intStat[i] <= 1'b0;
      else       intStat[i] <= (intStat[i] && !rdIsr) || setVec[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      intEn <= '0;
    else if (wrIer) intEn <= regWdata & EN_MASK;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(CFG_ADDR))      regRdata[2:1] = state;
    else if (regAddr == ADDR_W'(ISR_ADDR)) regRdata[EVT_BITS-1:0] = intStat;
    else if (regAddr == ADDR_W'(IER_ADDR)) regRdata = intEn;
  end

  assign irq = |(intStat & intEn[EVT_BITS-1:0]);

  // R8
  lof_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lofChg |=> intStat[0]);

  // R8
  oof_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.oofChg |=> intStat[1]);

  // R7
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIsr && !strobes.lofChg && !strobes.oofChg) |=> (intStat == '0));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intStat[0] && !rdIsr) |=> intStat[0]);

  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrIer && regWdata[EVT_BITS-1:0] == '0) |=> !irq);

endmodule

// File: rtl/plcp_frm_irq.sv
module plcp_frm_irq
  import plcp_frm_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evLost,
  input  logic              evTimeout,
  input  logic              evAcquired,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              rxOof,
  output logic              rxLof,
  output logic              irq
);

  frmState_t  state;
  frmStrobe_t strobes;

  frm_state_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evLost     (evLost),
    .evTimeout  (evTimeout),
    .evAcquired (evAcquired),
    .state      (state),
    .strobes    (strobes)
  );

  frm_irq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .state    (state),
    .strobes  (strobes),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .irq      (irq)
  );

  assign rxOof = state[1];
  assign rxLof = state[0];

  // R2
  lof_implies_oof_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxLof |-> rxOof);

endmodule

// File: tb/tb_plcp_frm_irq.sv
module tb_plcp_frm_irq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evLost = 1'b0, evTimeout = 1'b0, evAcquired = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic       rxOof, rxLof, irq;

  int errors = 0;
  int checks = 0;
  int mSt = 2; // 0 in-frame, 1 out-of-frame, 2 un-framed
  logic [7:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  plcp_frm_irq dut (
    .clk(clk), .rstN(rstN), .evLost(evLost), .evTimeout(evTimeout),
    .evAcquired(evAcquired), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .rxOof(rxOof), .rxLof(rxLof),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    regAddr = a; regRd = 1'b1;
    #1 v = regRdata;
    step();
    regRd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    regAddr = a; regWdata = v; regWr = 1'b1;
    step();
    regWr = 1'b0;
  endtask

  function automatic logic [7:0] cfgOf(input int s);
    return (s == 0) ? 8'h00 : (s == 1) ? 8'h04 : 8'h06;
  endfunction

  // Pulse the one applicable event until the model reaches the target state
  task automatic goTo(input int tgt);
    for (int n = 0; n < 3 && mSt != tgt; n++) begin
      evLost = (mSt == 0); evTimeout = (mSt == 1); evAcquired = (mSt == 2);
      step();
      evLost = 0; evTimeout = 0; evAcquired = 0;
      mSt = (mSt + 1) % 3;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1 reset state
    chk("R1 pins", {6'd0, rxOof, rxLof}, 8'h03);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(2'd2, v); chk("R1 mask", v, 8'h00);
    rd(2'd1, v); chk("R1 events", v, 8'h00);
    rd(2'd0, v); chk("R4 cfg unframed", v, 8'h06);

    // R2 R3 R4 R5 R6 sweep: every state x every pulse combination
    for (int s = 0; s < 3; s++) begin
      for (int e = 0; e < 8; e++) begin
        int nxt;
        logic [7:0] expEv;
        goTo(s);
        rd(2'd1, v);
        evLost = e[0]; evTimeout = e[1]; evAcquired = e[2];
        step();
        evLost = 0; evTimeout = 0; evAcquired = 0;
        nxt = s;
        if (s == 0 && e[0]) nxt = 1;
        if (s == 1 && e[1]) nxt = 2;
        if (s == 2 && e[2]) nxt = 0;
        expEv = 8'h00;
        if (s == 1 && nxt == 2) expEv = 8'h01; // R5
        if (s == 0 && nxt == 1) expEv = 8'h02; // R6
        if (s == 2 && nxt == 0) expEv = 8'h03; // R5 R6
        mSt = nxt;
        chk("R2 R3 pins", {6'd0, rxOof, rxLof},
            {6'd0, (nxt != 0) ? 1'b1 : 1'b0, (nxt == 2) ? 1'b1 : 1'b0});
        rd(2'd0, v); chk("R4 R3 cfg", v, cfgOf(nxt));
        rd(2'd1, v); chk("R5 R6 R3 events", v, expEv);
        rd(2'd1, v); chk("R7 cleared", v, 8'h00);
      end
    end

    // R10 R9: every mask value x each event-producing step
    for (int en = 0; en < 4; en++) begin
      for (int t = 0; t < 3; t++) begin
        logic [7:0] bits;
        goTo(t);
        rd(2'd1, v);
        wr(2'd2, 8'(en));
        evLost = (t == 0); evTimeout = (t == 1); evAcquired = (t == 2);
        step();
        evLost = 0; evTimeout = 0; evAcquired = 0;
        mSt = (t + 1) % 3;
        bits = (t == 0) ? 8'h02 : (t == 1) ? 8'h01 : 8'h03;
        chk("R10 irq", {7'd0, irq}, {7'd0, ((bits & 8'(en)) != 0) ? 1'b1 : 1'b0});
        step();
        chk("R7 sticky irq", {7'd0, irq}, {7'd0, ((bits & 8'(en)) != 0) ? 1'b1 : 1'b0});
        rd(2'd1, v); chk("R7 events", v, bits);
        chk("R10 irq after clear", {7'd0, irq}, 8'h00);
      end
    end

    // R9 unused bits and other offsets
    wr(2'd2, 8'hFC); rd(2'd2, v); chk("R9 unused bits", v, 8'h00);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R9 mask readback", v, 8'h03);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R9 event write ignored", v, 8'h00);
    chk("R9 irq", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R9 cfg write ignored", v, cfgOf(mSt));
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R9 offset3", v, 8'h00);
    rd(2'd2, v); chk("R9 mask kept", v, 8'h03);

    // R8 event coincides with clearing read
    goTo(0);
    rd(2'd1, v);
    regAddr = 2'd1; regRd = 1'b1; evLost = 1'b1;
    #1 d = regRdata;
    step();
    regRd = 1'b0; evLost = 1'b0; mSt = 1;
    chk("R8 read value", d, 8'h00);
    chk("R8 irq", {7'd0, irq}, 8'h01);
    rd(2'd1, v); chk("R8 event kept", v, 8'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule